// File: doc/BRIEF.md
# Two-Pass Block Transform Sequencer

This block is the control unit of a two-dimensional 8x8 block-transform accelerator. Software sets a start bit in a small control/status register through a simple bus slave port. The sequencer then reads one 8x8 block of 8-bit pixels from an input RAM through a 32-bit read port. It presents each assembled 64-bit row to an external one-dimensional transform unit and stores the 12-bit row results in an internal transpose buffer.

Once the whole block has passed the row pass, the sequencer sends one buffer column per cycle back through the same kind of transform. It keeps the 16-bit column results and hands them in pairs to an external quantiser. Each quantised 32-bit word goes to an output RAM. When the last word has been written, a ready flag is raised. The transform and the quantiser are outside the block. The transform is a fixed-latency pipeline with latency `TRANSFORM_LATENCY`, and the quantiser is combinational from `q_in` to `q_out`. The sequencer never waits on a handshake: it counts cycles.

Top module: `block_xform_seq`

## Requirements
- R1: After reset, the register reads 0, `busy` is 0, `bus_ack` is 0, and none of `in_rd`, `xf_row_valid`, `xf_col_valid` and `out_we` is asserted.
- R2: The register read value is {30'b0, ready, start} on `bus_rdata` at all times, with start in bit 0 and ready in bit 1. A write with bit 0 set while idle is accepted at that clock edge. In the next cycle, start reads 1, `busy` is 1 and `bus_ack` is 1. One cycle later, start has cleared itself and the first input read is issued.
- R3: The input RAM is read on 16 consecutive cycles at addresses 0,1,...,15. Data returns one cycle after `in_rd`. Word 2r holds pixels 0..3 of row r and word 2r+1 holds pixels 4..7, with pixel k of a word in bits 8(k mod 4)+7 down to 8(k mod 4).
- R4: In the cycle after the second word of row r is read, `xf_row_valid` is high and `xf_row_data` carries {word 2r+1, word 2r}, so pixel k sits in bits 8k+7:8k. The 8 rows follow at a spacing of 2 cycles.
- R5: `xf_row_res` is sampled `TRANSFORM_LATENCY` cycles after each row is presented. It holds 8 signed 12-bit results, with result k in bits 12k+11:12k, and is stored as row r of the transpose buffer.
- R6: Column issue starts `TRANSFORM_LATENCY`+1 cycles after the last row is presented, that is, only after all 8 row results are stored. Columns 0..7 go out on 8 consecutive cycles, and element r of column c (bits 12r+11:12r) is row r's result c.
- R7: `xf_col_res` is sampled `TRANSFORM_LATENCY` cycles after each column is issued. It holds 8 signed 16-bit results, with result k in bits 16k+15:16k.
- R8: The output RAM is written on 32 consecutive cycles at addresses 0..31. For word w, `q_in` carries column w/4's results 2(w mod 4) in bits 15:0 and 2(w mod 4)+1 in bits 31:16, and `out_wdata` equals `q_out`.
- R9: Ready rises in the cycle after the last output write has been followed by one closing cycle, and `busy` falls at the same edge. `busy` stays high for 59+2*`TRANSFORM_LATENCY` cycles per block, and ready and `busy` are never high together.
- R10: A write while `busy` is high has no effect: start stays 0, no extra input reads occur and the run length is unchanged. A write with bit 0 clear has no effect either.
- R11: An accepted start clears a ready flag left over from the previous block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_stb | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | 32 | Bus write data, bit 0 is start |
| bus_ack | output | 1 | One-cycle acknowledge for each access |
| bus_rdata | output | 32 | Register read value {30'b0, ready, start} |
| busy | output | 1 | High from the accepted start until ready |
| in_rd | output | 1 | Input RAM read enable |
| in_addr | output | 4 | Input RAM word address |
| in_data | input | 32 | Input RAM read data, one cycle after in_rd |
| xf_row_valid | output | 1 | Row presented to the transform |
| xf_row_data | output | 64 | Eight 8-bit pixels of one row |
| xf_row_res | input | 96 | Eight 12-bit row-pass results |
| xf_col_valid | output | 1 | Column presented to the transform |
| xf_col_data | output | 96 | Eight 12-bit elements of one column |
| xf_col_res | input | 128 | Eight 16-bit column-pass results |
| q_in | output | 32 | Pair of 16-bit results to the quantiser |
| q_out | input | 32 | Quantised pair from the quantiser |
| out_we | output | 1 | Output RAM write enable |
| out_addr | output | 5 | Output RAM word address |
| out_wdata | output | 32 | Output RAM write data |

## Verification
A wrong phase counter shows at the ports within a cycle or two. `in_addr` or `out_addr` skips or repeats a value, a read burst runs past 16 words, or the column burst starts early relative to the last row. The bench measures each of these gaps in cycles. If a row or column lands in the wrong buffer slot, or the pipeline depth is counted wrongly, the cycle timing still looks correct. Those faults appear only as wrong data in the output words, so every one of the 32 words is compared against a model computed from the input image. A wrong register state shows up in `bus_rdata` and in the length of the `busy` window.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int BLK       = 8;
  localparam int PIX_W     = 8;
  localparam int ROW_RES_W = 12;
  localparam int COL_RES_W = 16;
  localparam int WORD_W    = 32;

  localparam int IN_WORDS  = BLK * BLK * PIX_W / WORD_W;
  localparam int OUT_WORDS = BLK * BLK * COL_RES_W / WORD_W;
  localparam int IN_AW     = $clog2(IN_WORDS);
  localparam int OUT_AW    = $clog2(OUT_WORDS);
  localparam int IDX_W     = $clog2(BLK);
  localparam int PAIR_AW   = $clog2(BLK / 2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_FETCH,
    ST_ROW_DRAIN,
    ST_COL_ISSUE,
    ST_COL_DRAIN,
    ST_OUT_WRITE,
    ST_DONE
  } seq_state_t;

  // lower-indexed coefficient goes into the low half of the word
  function automatic logic [WORD_W-1:0] pack_pair(input logic [COL_RES_W-1:0] lo,
                                                  input logic [COL_RES_W-1:0] hi);
    return {hi, lo};
  endfunction

  // first-read word holds the lower pixel indices
  function automatic logic [2*WORD_W-1:0] join_words(input logic [WORD_W-1:0] first,
                                                     input logic [WORD_W-1:0] second);
    return {second, first};
  endfunction
endpackage

// File: rtl/xs_csr.sv
module xs_csr
  import xs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              fsm_idle,
  input  logic              done_pulse,
  output logic              go,
  output logic              busy
);
  logic start_q, ready_q, ack_q;
  logic wr_first, accept;
  logic wdata_unused;

  assign wdata_unused = ^bus_wdata[WORD_W-1:1];
  assign wr_first     = bus_stb & bus_we & ~ack_q;
  assign busy         = start_q | ~fsm_idle;
  assign accept       = wr_first & bus_wdata[0] & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      ready_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= bus_stb & ~ack_q;
      if (accept) begin
        start_q <= 1'b1;
        ready_q <= 1'b0;
      end else begin
        start_q <= 1'b0;
        if (done_pulse) ready_q <= 1'b1;
      end
    end
  end

  assign go        = start_q;
  assign bus_ack   = ack_q;
  assign bus_rdata = {{(WORD_W-2){1'b0}}, ready_q, start_q};

  // R2
  start_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R10
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_first && busy && !done_pulse) |=> (!start_q && $stable(ready_q)));
  // R9
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready_q && busy));
  // R11
  start_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!ready_q && busy));
endmodule

// File: rtl/xs_fsm.sv
module xs_fsm
  import xs_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              fsm_idle,
  output logic              done_pulse,
  output logic              in_rd,
  output logic [IN_AW-1:0]  in_addr,
  output logic              lo_latch,
  output logic              row_valid,
  output logic              row_wr,
  output logic [IDX_W-1:0]  row_wr_idx,
  output logic              col_valid,
  output logic [IDX_W-1:0]  col_idx,
  output logic              col_wr,
  output logic [IDX_W-1:0]  col_wr_idx,
  output logic              out_we,
  output logic [OUT_AW-1:0] out_addr
);
  localparam int CMAX  = (LAT + 1 > OUT_WORDS) ? LAT + 1 : OUT_WORDS;
  localparam int CNT_W = $clog2(CMAX + 1);
  localparam int RC_W  = $clog2(BLK + 1);
  localparam int OC_W  = $clog2(OUT_WORDS + 1);

  seq_state_t       state, nxt;
  logic [CNT_W-1:0] cnt;
  logic             rd_q, rd_odd_q;
  logic [LAT-1:0]   rvp, cvp;
  logic [RC_W-1:0]  rows_done, cols_done;
  logic [OC_W-1:0]  outs_done;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      if (go) nxt = ST_ROW_FETCH;
      ST_ROW_FETCH: if (cnt == CNT_W'(IN_WORDS - 1)) nxt = ST_ROW_DRAIN;
      ST_ROW_DRAIN: if (cnt == CNT_W'(LAT)) nxt = ST_COL_ISSUE;
      ST_COL_ISSUE: if (cnt == CNT_W'(BLK - 1)) nxt = ST_COL_DRAIN;
      ST_COL_DRAIN: if (cnt == CNT_W'(LAT - 1)) nxt = ST_OUT_WRITE;
      ST_OUT_WRITE: if (cnt == CNT_W'(OUT_WORDS - 1)) nxt = ST_DONE;
      ST_DONE:      nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
    end
  end

  assign fsm_idle   = (state == ST_IDLE);
  assign done_pulse = (state == ST_DONE);
  assign in_rd      = (state == ST_ROW_FETCH);
  assign in_addr    = cnt[IN_AW-1:0];
  assign col_valid  = (state == ST_COL_ISSUE);
  assign col_idx    = cnt[IDX_W-1:0];
  assign out_we     = (state == ST_OUT_WRITE);
  assign out_addr   = cnt[OUT_AW-1:0];

  // read data returns one cycle after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      rd_odd_q <= 1'b0;
    end else begin
      rd_q     <= in_rd;
      rd_odd_q <= in_addr[0];
    end
  end
  assign lo_latch  = rd_q & ~rd_odd_q;
  assign row_valid = rd_q & rd_odd_q;

  // fixed-latency tracking of the external transform
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvp <= '0;
      cvp <= '0;
    end else begin
      rvp[0] <= row_valid;
      cvp[0] <= col_valid;
      for (int i = 1; i < LAT; i++) begin
        rvp[i] <= rvp[i-1];
        cvp[i] <= cvp[i-1];
      end
    end
  end
  assign row_wr = rvp[LAT-1];
  assign col_wr = cvp[LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_done <= '0;
      cols_done <= '0;
      outs_done <= '0;
    end else if (go) begin
      rows_done <= '0;
      cols_done <= '0;
      outs_done <= '0;
    end else begin
      if (row_wr) rows_done <= rows_done + 1'b1;
      if (col_wr) cols_done <= cols_done + 1'b1;
      if (out_we) outs_done <= outs_done + 1'b1;
    end
  end
  assign row_wr_idx = rows_done[IDX_W-1:0];
  assign col_wr_idx = cols_done[IDX_W-1:0];

  // R3
  in_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd && in_addr != '0) |-> ($past(in_rd) && in_addr == IN_AW'($past(in_addr) + 1'b1)));
  // R8
  out_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && out_addr != '0) |-> ($past(out_we) && out_addr == OUT_AW'($past(out_addr) + 1'b1)));
  // R5
  row_write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_wr |-> (state == ST_ROW_FETCH || state == ST_ROW_DRAIN));
  // R6
  col_after_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_valid) |-> (rows_done == RC_W'(BLK)));
  // R7
  col_write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_wr |-> (state == ST_COL_ISSUE || state == ST_COL_DRAIN));
  // R6
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_rd, col_valid, out_we}));
  // R9
  ready_after_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (outs_done == OC_W'(OUT_WORDS) && cols_done == RC_W'(BLK)));
endmodule

// File: rtl/xs_transpose.sv
module xs_transpose
  import xs_pkg::*;
(
  input  logic                     clk,
  input  logic                     we,
  input  logic [IDX_W-1:0]         wrow,
  input  logic [BLK*ROW_RES_W-1:0] wdata,
  input  logic [IDX_W-1:0]         rcol,
  output logic [BLK*ROW_RES_W-1:0] rdata
);
  logic [ROW_RES_W-1:0] mem [BLK][BLK];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < BLK; k++) mem[wrow][k] <= wdata[k*ROW_RES_W +: ROW_RES_W];
    end
  end

  for (genvar r = 0; r < BLK; r++) begin : g_col
    assign rdata[r*ROW_RES_W +: ROW_RES_W] = mem[r][rcol];
  end
endmodule

// File: rtl/xs_colbuf.sv
module xs_colbuf
  import xs_pkg::*;
(
  input  logic                     clk,
  input  logic                     we,
  input  logic [IDX_W-1:0]         wcol,
  input  logic [BLK*COL_RES_W-1:0] wdata,
  input  logic [OUT_AW-1:0]        rword,
  output logic [WORD_W-1:0]        rdata
);
  logic [COL_RES_W-1:0] mem [BLK][BLK];
  logic [IDX_W-1:0]     rsel_col;
  logic [PAIR_AW-1:0]   rsel_pair;

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < BLK; k++) mem[wcol][k] <= wdata[k*COL_RES_W +: COL_RES_W];
    end
  end

  assign rsel_col  = rword[OUT_AW-1:PAIR_AW];
  assign rsel_pair = rword[PAIR_AW-1:0];
  assign rdata     = pack_pair(mem[rsel_col][{rsel_pair, 1'b0}],
                               mem[rsel_col][{rsel_pair, 1'b1}]);
endmodule

// File: rtl/block_xform_seq.sv
module block_xform_seq
  import xs_pkg::*;
#(
  parameter int TRANSFORM_LATENCY = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_stb,
  input  logic                     bus_we,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic                     bus_ack,
  output logic [WORD_W-1:0]        bus_rdata,
  output logic                     busy,
  output logic                     in_rd,
  output logic [IN_AW-1:0]         in_addr,
  input  logic [WORD_W-1:0]        in_data,
  output logic                     xf_row_valid,
  output logic [BLK*PIX_W-1:0]     xf_row_data,
  input  logic [BLK*ROW_RES_W-1:0] xf_row_res,
  output logic                     xf_col_valid,
  output logic [BLK*ROW_RES_W-1:0] xf_col_data,
  input  logic [BLK*COL_RES_W-1:0] xf_col_res,
  output logic [WORD_W-1:0]        q_in,
  input  logic [WORD_W-1:0]        q_out,
  output logic                     out_we,
  output logic [OUT_AW-1:0]        out_addr,
  output logic [WORD_W-1:0]        out_wdata
);
  logic              go, fsm_idle, done_pulse;
  logic              lo_latch, row_wr, col_wr;
  logic [IDX_W-1:0]  row_wr_idx, col_idx, col_wr_idx;
  logic [WORD_W-1:0] lo_word;

  xs_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_stb    (bus_stb),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .fsm_idle   (fsm_idle),
    .done_pulse (done_pulse),
    .go         (go),
    .busy       (busy)
  );

  xs_fsm #(.LAT(TRANSFORM_LATENCY)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .fsm_idle   (fsm_idle),
    .done_pulse (done_pulse),
    .in_rd      (in_rd),
    .in_addr    (in_addr),
    .lo_latch   (lo_latch),
    .row_valid  (xf_row_valid),
    .row_wr     (row_wr),
    .row_wr_idx (row_wr_idx),
    .col_valid  (xf_col_valid),
    .col_idx    (col_idx),
    .col_wr     (col_wr),
    .col_wr_idx (col_wr_idx),
    .out_we     (out_we),
    .out_addr   (out_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lo_word <= '0;
    else if (lo_latch) lo_word <= in_data;
  end
  assign xf_row_data = join_words(lo_word, in_data);

  xs_transpose u_tbuf (
    .clk   (clk),
    .we    (row_wr),
    .wrow  (row_wr_idx),
    .wdata (xf_row_res),
    .rcol  (col_idx),
    .rdata (xf_col_data)
  );

  xs_colbuf u_cbuf (
    .clk   (clk),
    .we    (col_wr),
    .wcol  (col_wr_idx),
    .wdata (xf_col_res),
    .rword (out_addr),
    .rdata (q_in)
  );

  assign out_wdata = q_out;
endmodule

// File: tb/block_xform_seq_tb.sv
`timescale 1ns/1ps
module block_xform_seq_tb;
  localparam int LAT = 3;
  localparam int RUN_CYCLES = 59 + 2 * LAT;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_stb = 1'b0, bus_we = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_ack;
  logic [31:0]  bus_rdata;
  logic         busy, in_rd, xf_row_valid, xf_col_valid, out_we;
  logic [3:0]   in_addr;
  logic [31:0]  in_data = '0;
  logic [63:0]  xf_row_data;
  logic [95:0]  xf_row_res, xf_col_data;
  logic [127:0] xf_col_res;
  logic [31:0]  q_in, q_out, out_wdata;
  logic [4:0]   out_addr;

  always #2 clk = ~clk;

  block_xform_seq #(.TRANSFORM_LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .in_rd(in_rd), .in_addr(in_addr),
    .in_data(in_data), .xf_row_valid(xf_row_valid), .xf_row_data(xf_row_data),
    .xf_row_res(xf_row_res), .xf_col_valid(xf_col_valid), .xf_col_data(xf_col_data),
    .xf_col_res(xf_col_res), .q_in(q_in), .q_out(q_out), .out_we(out_we),
    .out_addr(out_addr), .out_wdata(out_wdata)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] in_mem [16];
  logic [31:0] out_mem [32];

  // external transform models
  function automatic logic [95:0] row_xf(input logic [63:0] px);
    logic [95:0] r;
    for (int k = 0; k < 8; k++) r[12*k +: 12] = 12'({4'b0, px[8*k +: 8]}) - 12'd128 + 12'(3*k);
    return r;
  endfunction
  function automatic logic [127:0] col_xf(input logic [95:0] c);
    logic [127:0] r;
    logic [15:0]  e;
    for (int k = 0; k < 8; k++) begin
      e = {{4{c[12*k+11]}}, c[12*k +: 12]};
      r[16*k +: 16] = (e << 2) - 16'(k);
    end
    return r;
  endfunction
  assign q_out = {q_in[31], q_in[31:17], q_in[15], q_in[15:1]};

  logic [95:0]  rpipe [LAT];
  logic [127:0] cpipe [LAT];
  always @(posedge clk) begin
    rpipe[0] <= row_xf(xf_row_data);
    cpipe[0] <= col_xf(xf_col_data);
    for (int i = 1; i < LAT; i++) begin
      rpipe[i] <= rpipe[i-1];
      cpipe[i] <= cpipe[i-1];
    end
  end
  assign xf_row_res = rpipe[LAT-1];
  assign xf_col_res = cpipe[LAT-1];

  // port monitors, monotonic counters only
  int cyc = 0, rd_tot = 0, rd_err = 0, row_tot = 0, col_tot = 0;
  int out_tot = 0, out_err = 0, busy_tot = 0;
  logic prev_rd = 1'b0, prev_we = 1'b0;
  logic [3:0] prev_ra = '0;
  logic [4:0] prev_wa = '0;
  logic [63:0] row_log [8];
  logic [95:0] col_log [8];
  int row_cyc [8];
  int col_cyc [8];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (in_rd) begin
      in_data <= in_mem[in_addr];
      rd_tot  <= rd_tot + 1;
      if (32'(in_addr) != (prev_rd ? 32'(prev_ra) + 1 : 0)) rd_err <= rd_err + 1;
    end
    prev_rd <= in_rd;
    prev_ra <= in_addr;
    if (xf_row_valid) begin
      row_log[row_tot % 8] <= xf_row_data;
      row_cyc[row_tot % 8] <= cyc;
      row_tot <= row_tot + 1;
    end
    if (xf_col_valid) begin
      col_log[col_tot % 8] <= xf_col_data;
      col_cyc[col_tot % 8] <= cyc;
      col_tot <= col_tot + 1;
    end
    if (out_we) begin
      out_mem[out_addr] <= out_wdata;
      out_tot <= out_tot + 1;
      if (32'(out_addr) != (prev_we ? 32'(prev_wa) + 1 : 0)) out_err <= out_err + 1;
    end
    prev_we <= out_we;
    prev_wa <= out_addr;
    if (busy) busy_tot <= busy_tot + 1;
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected values from the requirements
  function automatic logic [7:0] pix_gen(input int pat, input int w, input int b);
    case (pat)
      0:       return 8'(w*4 + b);
      1:       return 8'hFF;
      2:       return 8'(w*37 + b*91 + 13);
      default: return ((w + b) % 2 == 1) ? 8'h80 : 8'h7F;
    endcase
  endfunction
  function automatic logic [11:0] exp_rowres(input int r, input int k);
    logic [7:0] p;
    p = in_mem[2*r + k/4][8*(k%4) +: 8];
    return 12'({4'b0, p}) - 12'd128 + 12'(3*k);
  endfunction
  function automatic logic [15:0] exp_colres(input int c, input int k);
    logic [11:0] t;
    logic [15:0] e;
    t = exp_rowres(k, c);
    e = {{4{t[11]}}, t};
    return (e << 2) - 16'(k);
  endfunction
  function automatic logic [31:0] exp_word(input int w);
    logic [15:0] lo, hi;
    lo = exp_colres(w/4, 2*(w%4));
    hi = exp_colres(w/4, 2*(w%4) + 1);
    return {hi[15], hi[15:1], lo[15], lo[15:1]};
  endfunction
  function automatic logic [95:0] exp_col(input int c);
    logic [95:0] v;
    for (int r = 0; r < 8; r++) v[12*r +: 12] = exp_rowres(r, c);
    return v;
  endfunction

  task automatic csr_write(input logic [31:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_stb = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic t_reset;
    chk("R1 register", 128'(bus_rdata), 128'd0);
    chk("R1 busy/ack", 128'({busy, bus_ack}), 128'd0);
    chk("R1 enables", 128'({in_rd, xf_row_valid, xf_col_valid, out_we}), 128'd0);
  endtask

  task automatic t_run_block(input int pat, input int poke_at);
    int rd0, re0, row0, col0, out0, oe0, busy0, waited;
    logic prior_ready;
    bit sp_ok;
    for (int w = 0; w < 16; w++)
      for (int b = 0; b < 4; b++) in_mem[w][8*b +: 8] = pix_gen(pat, w, b);
    @(negedge clk);
    prior_ready = bus_rdata[1];
    rd0 = rd_tot; re0 = rd_err; row0 = row_tot; col0 = col_tot;
    out0 = out_tot; oe0 = out_err; busy0 = busy_tot;
    csr_write(32'h1);
    chk("R2 start read/ack/busy", 128'({bus_rdata[1:0], bus_ack, busy}), 128'b0111);
    if (prior_ready) chk("R11 ready cleared by start", 128'(bus_rdata[1]), 128'd0);
    @(negedge clk);
    chk("R2 start self-clear", 128'({bus_rdata[0], bus_ack}), 128'd0);
    chk("R3 first read addr 0", 128'({in_rd, in_addr}), 128'({1'b1, 4'd0}));
    if (poke_at > 0) begin
      repeat (poke_at) @(negedge clk);
      csr_write(32'h1);
      chk("R10 start while busy", 128'({bus_rdata[0], busy}), 128'b01);
    end
    waited = 0;
    while (!bus_rdata[1] && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    chk("R9 ready raised", 128'(bus_rdata[1]), 128'd1);
    chk("R9 busy low at ready", 128'(busy), 128'd0);
    chk("R9/R10 busy length", 128'(busy_tot - busy0), 128'(RUN_CYCLES));
    chk("R3/R10 read count", 128'(rd_tot - rd0), 128'd16);
    chk("R3 read address order", 128'(rd_err - re0), 128'd0);
    chk("R4 row count", 128'(row_tot - row0), 128'd8);
    for (int r = 0; r < 8; r++)
      chk($sformatf("R4 row %0d data", r), 128'(row_log[r]), 128'({in_mem[2*r+1], in_mem[2*r]}));
    sp_ok = 1;
    for (int r = 1; r < 8; r++) if (row_cyc[r] - row_cyc[r-1] != 2) sp_ok = 0;
    chk("R4 row spacing", 128'(sp_ok), 128'd1);
    chk("R6 column count", 128'(col_tot - col0), 128'd8);
    chk("R6 column start gap", 128'(col_cyc[0] - row_cyc[7]), 128'(LAT + 1));
    sp_ok = 1;
    for (int c = 1; c < 8; c++) if (col_cyc[c] - col_cyc[c-1] != 1) sp_ok = 0;
    chk("R6 column spacing", 128'(sp_ok), 128'd1);
    for (int c = 0; c < 8; c++)
      chk($sformatf("R5/R6 column %0d data", c), 128'(col_log[c]), 128'(exp_col(c)));
    chk("R8 write count", 128'(out_tot - out0), 128'd32);
    chk("R8 write address order", 128'(out_err - oe0), 128'd0);
    for (int w = 0; w < 32; w++)
      chk($sformatf("R7/R8 word %0d", w), 128'(out_mem[w]), 128'(exp_word(w)));
  endtask

  task automatic t_zero_write;
    int rd0;
    rd0 = rd_tot;
    csr_write(32'h0);
    chk("R10 zero write register", 128'(bus_rdata), 128'd2);
    repeat (5) @(negedge clk);
    chk("R10 zero write busy", 128'(busy), 128'd0);
    chk("R10 zero write reads", 128'(rd_tot - rd0), 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_run_block(0, 0);
    t_run_block(1, 0);
    t_run_block(2, 10);
    t_zero_write();
    t_run_block(3, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end
endmodule